// File: doc/BRIEF.md
# LCD Frame Capture Addresser

This block sits between an 18-bit parallel RGB display feed and a 32-bit synchronous memory write port. The feed carries a pixel clock and a vertical sync, but no horizontal sync. The block therefore recovers the line position by counting pixel clocks: each line is 263 clocks long. A second counter tracks the line number. The two counts are concatenated into a sparse memory address, with the horizontal position in the low bits, and every captured pixel becomes one memory word.

Two screens share the same bus. One screen's data is valid at the rising clock edge and the other's at the falling edge, so a select input picks which one is stored. A programmable preload is loaded into the horizontal counter at the frame marker, which lets software shift the stored image sideways.

A small state machine controls capture:
- **IDLE**: the state after reset.
- **ARMED**: entered from IDLE or DONE on the `arm_seen`/`rearm` transitions when `arm` is high.
- **CAPTURE**: entered on the `frame_start` transition at the next frame marker.
- **DONE**: entered on the `frame_end` transition at the following frame marker. DONE holds `done` high.

Top module: `lcdcap_top`

## Requirements
- R1: A written word is `{14'b0, red[5:0], green[5:0], blue[5:0]}`: red in bits 17:12, green in bits 11:6, blue in bits 5:0, and bits 31:18 are zero.
- R2: With `edge_sel`=0, the stored pixel is the bus value present at the rising clock edge. With `edge_sel`=1, it is the bus value sampled at the falling edge half a period earlier.
- R3: The horizontal count runs 0 to 262 and then wraps to 0. It forms `mem_addr[8:0]`, so line offsets 263 to 511 are never written, and consecutive writes within a line step the address by one.
- R4: The line count forms `mem_addr[16:9]`. It is cleared at the frame marker, advances by one on the clock after the horizontal count is 262, and wraps from 255 to 0.
- R5: The first word of a capture has horizontal offset `h_preload` and line 0. A preload above 262 is treated as 0.
- R6: Only a rising edge of the synchronised `vsync` is a frame marker. A falling edge has no effect on the address sequence.
- R7: Suppose `vsync` first reads high at rising edge k. Then the marker takes effect at edge k+2, and the pixel of edge k+3 is the first one written. Each write appears on the outputs right after its pixel's edge.
- R8: Writes happen only in CAPTURE. Frame markers seen in IDLE, or in DONE without a re-arm, cause no writes.
- R9: Suppose the ending `vsync` rise first reads high at edge m. Then pixels through edge m+1 are written and none after that. `done` goes high at edge m+2 and stays high, with `mem_we` low, until the next `arm`.
- R10: During and after reset, `mem_we`, `done`, `mem_addr` and `mem_wdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Request capture of the next full frame |
| vsync | input | 1 | Vertical sync from the display feed |
| edge_sel | input | 1 | 0 selects rising-edge data, 1 selects falling-edge data |
| h_preload | input | 9 | Horizontal start offset loaded at the frame marker |
| red_in | input | 6 | Red channel |
| green_in | input | 6 | Green channel |
| blue_in | input | 6 | Blue channel |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 17 | Write address: line number in the high bits, horizontal offset in the low bits |
| mem_wdata | output | 32 | Write data, one pixel per word |
| done | output | 1 | Capture of one frame is complete |

## Verification
A `vsync` rise presented before rising edge k opens capture so that the pixel of edge k+3 is the first written. Every later pixel's write is visible after its own edge. The driver derives each expected address and word from that count alone, then queues it as it presents the pixel. The monitor samples at the falling edge that follows each rising edge and pops exactly one item per observed strobe, so a write that is one cycle early or late shows up as a wrong address or as an unexpected write. `done` is checked after the ending marker has had two edges to act, and again in the middle of a capture, where it must still be low.

// File: rtl/lcdcap_pkg.sv
package lcdcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } cap_state_t;

    localparam int N_CHAN = 3;
endpackage

// File: rtl/lcdcap_vsync_sync.sv
module lcdcap_vsync_sync #(
    parameter bit VS_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    output logic frame_evt
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= vsync;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    generate
        if (VS_RISE) begin : g_rise
            assign frame_evt = sync_q & ~prev_q;
        end else begin : g_fall
            assign frame_evt = ~sync_q & prev_q;
        end
    endgenerate
endmodule

// File: rtl/lcdcap_pix_sample.sv
module lcdcap_pix_sample #(
    parameter int CH_W = 6
) (
    input  logic                 clk,
    input  logic                 edge_sel,
    input  logic [CH_W-1:0]      red_in,
    input  logic [CH_W-1:0]      green_in,
    input  logic [CH_W-1:0]      blue_in,
    output logic [3*CH_W-1:0]    pix_out
);
    localparam int NC = lcdcap_pkg::N_CHAN;

    logic [NC-1:0][CH_W-1:0] chan_in;
    logic [NC-1:0][CH_W-1:0] fall_q;
    logic [NC-1:0][CH_W-1:0] chan_sel;

    assign chan_in = {red_in, green_in, blue_in};

    generate
        for (genvar g = 0; g < NC; g++) begin : g_chan
            always_ff @(negedge clk) begin
                fall_q[g] <= chan_in[g];
            end
            assign chan_sel[g] = edge_sel ? fall_q[g] : chan_in[g];
        end
    endgenerate

    assign pix_out = chan_sel;
endmodule

// File: rtl/lcdcap_pos_counter.sv
module lcdcap_pos_counter #(
    parameter int H_TOTAL = 263,
    parameter int V_W     = 8,
    parameter int H_W     = $clog2(H_TOTAL)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [H_W-1:0] preload,
    output logic [H_W-1:0] h_cnt,
    output logic [V_W-1:0] v_cnt
);
    localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);

    logic [H_W-1:0] start_val;
    logic           line_end;

    assign start_val = (preload > H_LAST) ? '0 : preload;
    assign line_end  = (h_cnt == H_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (load) begin
            h_cnt <= start_val;
            v_cnt <= '0;
        end else begin
            h_cnt <= line_end ? '0 : h_cnt + 1'b1;
            if (line_end) begin
                v_cnt <= v_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcdcap_top.sv
module lcdcap_top #(
    parameter int CH_W    = 6,
    parameter int H_TOTAL = 263,
    parameter int V_W     = 8,
    parameter int MEM_W   = 32,
    parameter bit VS_RISE = 1'b1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  arm,
    input  logic                                  vsync,
    input  logic                                  edge_sel,
    input  logic [$clog2(H_TOTAL)-1:0]            h_preload,
    input  logic [CH_W-1:0]                       red_in,
    input  logic [CH_W-1:0]                       green_in,
    input  logic [CH_W-1:0]                       blue_in,
    output logic                                  mem_we,
    output logic [V_W+$clog2(H_TOTAL)-1:0]        mem_addr,
    output logic [MEM_W-1:0]                      mem_wdata,
    output logic                                  done
);
    import lcdcap_pkg::*;

    localparam int PIX_W  = 3 * CH_W;
    localparam int H_W    = $clog2(H_TOTAL);
    localparam int ADDR_W = V_W + H_W;

    cap_state_t     state_q, state_nxt;
    logic           vs_evt;
    logic           wr_now;
    logic [H_W-1:0] h_cnt;
    logic [V_W-1:0] v_cnt;
    logic [PIX_W-1:0] pix;

    lcdcap_vsync_sync #(.VS_RISE(VS_RISE)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync     (vsync),
        .frame_evt (vs_evt)
    );

    lcdcap_pix_sample #(.CH_W(CH_W)) u_pix (
        .clk      (clk),
        .edge_sel (edge_sel),
        .red_in   (red_in),
        .green_in (green_in),
        .blue_in  (blue_in),
        .pix_out  (pix)
    );

    lcdcap_pos_counter #(.H_TOTAL(H_TOTAL), .V_W(V_W), .H_W(H_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (vs_evt),
        .preload (h_preload),
        .h_cnt   (h_cnt),
        .v_cnt   (v_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Transitions: arm_seen, frame_start, frame_end, rearm
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:    if (arm)    state_nxt = ST_ARMED;
            ST_ARMED:   if (vs_evt) state_nxt = ST_CAPTURE;
            ST_CAPTURE: if (vs_evt) state_nxt = ST_DONE;
            ST_DONE:    if (arm)    state_nxt = ST_ARMED;
            default:                state_nxt = ST_IDLE;
        endcase
    end

    assign wr_now = (state_q == ST_CAPTURE) && !vs_evt;

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
        end else begin
            mem_we <= wr_now;
            done   <= (state_nxt == ST_DONE);
            if (wr_now) begin
                mem_addr  <= ADDR_W'({v_cnt, h_cnt});
                mem_wdata <= {{(MEM_W-PIX_W){1'b0}}, pix};
            end
        end
    end
endmodule

// File: rtl/lcdcap_checker.sv
module lcdcap_checker #(
    parameter int H_TOTAL = 263,
    parameter int V_W     = 8,
    parameter int MEM_W   = 32,
    parameter int PIX_W   = 18
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                mem_we,
    input logic [V_W+$clog2(H_TOTAL)-1:0]      mem_addr,
    input logic [MEM_W-1:0]                    mem_wdata,
    input logic                                done,
    input logic                                vs_evt
);
    localparam int H_W = $clog2(H_TOTAL);
    localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);

    logic [H_W-1:0] a_h;
    logic [V_W-1:0] a_v;
    assign a_h = mem_addr[H_W-1:0];
    assign a_v = mem_addr[V_W+H_W-1:H_W];

    assert_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata[MEM_W-1:PIX_W] == '0));

    assert_h_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (a_h <= H_LAST));

    assert_h_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && ($past(a_h) != H_LAST))
        |-> (a_h == $past(a_h) + 1'b1) && (a_v == $past(a_v)));

    assert_v_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && ($past(a_h) == H_LAST))
        |-> (a_h == '0) && (a_v == $past(a_v) + 1'b1));

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

    assert_evt_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vs_evt |=> !vs_evt);
endmodule

bind lcdcap_top lcdcap_checker #(
    .H_TOTAL (H_TOTAL),
    .V_W     (V_W),
    .MEM_W   (MEM_W),
    .PIX_W   (PIX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .vs_evt    (vs_evt)
);

// File: tb/sim_lcdcap_top.sv
module sim_lcdcap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        vsync = 1'b0;
    logic        edge_sel = 1'b0;
    logic [8:0]  h_preload = '0;
    logic [5:0]  red_in = '0, green_in = '0, blue_in = '0;
    logic        mem_we;
    logic [16:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [16:0] addr;
        logic [31:0] data;
        string       tag;
    } item_t;

    item_t exp_q[$];

    always #5 clk = ~clk;

    lcdcap_top u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .vsync(vsync),
        .edge_sel(edge_sel), .h_preload(h_preload),
        .red_in(red_in), .green_in(green_in), .blue_in(blue_in),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(done)
    );

    function automatic logic [17:0] top_val(int j);
        return 18'((j * 37 + 5) ^ 18'h15A5A);
    endfunction

    function automatic logic [17:0] bot_val(int j);
        return 18'((j * 101 + 9) ^ 18'h0C3C3);
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Monitor: one scoreboard pop per observed write strobe
    always @(negedge clk) begin
        if (rst_n && mem_we && !finished) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected write addr", longint'(mem_addr), 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(mem_addr == it.addr, it.tag, "addr", longint'(mem_addr), longint'(it.addr));
                check(mem_wdata == it.data, it.tag, "data", longint'(mem_wdata), longint'(it.data));
            end
        end
    end

    task automatic pulse_arm();
        @(posedge clk); #1 arm = 1'b1;
        @(posedge clk); #1 arm = 1'b0;
    endtask

    // Driver: one pixel per clock, expected words queued as they are presented
    task automatic run_frame(bit sel, int pre, int npix, bit capture, bit exp_done);
        int pe;
        pe = (pre > 262) ? 0 : pre;
        edge_sel = sel;
        h_preload = 9'(pre);
        for (int j = 0; j < npix + 8; j++) begin
            @(posedge clk); #1;
            vsync = (j < npix / 2) || (j >= npix && j < npix + 4);
            {red_in, green_in, blue_in} = top_val(j);
            @(negedge clk); #1;
            {red_in, green_in, blue_in} = bot_val(j);
            if (capture && j == npix / 2)
                check(done == 1'b0, "R9", "done during capture", longint'(done), 0);
            if (capture && j >= 3 && j <= npix + 1) begin
                item_t it;
                int n;
                n = j - 3 + pe;
                it.addr = {8'((n / 263) % 256), 9'(n % 263)};
                it.data = {14'b0, (sel ? top_val(j) : bot_val(j))};
                if (j == 3)                                       it.tag = "R5/R7";
                else if (j >= npix / 2 + 2 && j <= npix / 2 + 5)  it.tag = "R6";
                else if (j == npix + 1)                           it.tag = "R9";
                else if (sel)                                     it.tag = "R2";
                else                                              it.tag = "R1/R3/R4";
                exp_q.push_back(it);
            end
        end
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R9", "missing writes", longint'(exp_q.size()), 0);
        exp_q.delete();
        check(done == exp_done, "R9", "done after frame", longint'(done), longint'(exp_done));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_we == 0 && done == 0, "R10", "reset strobes", longint'({mem_we, done}), 0);
        check(mem_addr == 0 && mem_wdata == 0, "R10", "reset bus", longint'(mem_wdata), 0);
        #1 rst_n = 1'b1;

        run_frame(1'b0, 0, 40, 1'b0, 1'b0);       // R8: not armed, no writes
        pulse_arm();
        run_frame(1'b0, 0, 600, 1'b1, 1'b1);      // R1 R3 R4 R6 R7 R9, rising-edge data
        run_frame(1'b0, 0, 40, 1'b0, 1'b1);       // R8: in DONE without re-arm
        pulse_arm();
        run_frame(1'b1, 250, 300, 1'b1, 1'b1);    // R2 falling-edge data, R5 preload
        pulse_arm();
        run_frame(1'b0, 300, 50, 1'b1, 1'b1);     // R5 out-of-range preload treated as 0
        pulse_arm();
        run_frame(1'b1, 262, 263 * 256 + 10, 1'b1, 1'b1); // R4 line count wrap

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule